// File: doc/BRIEF.md
# Cache Line Atomic Access Unit

This unit carries out the data part of one processor request against a cache line that the surrounding cache has already looked up. A request is a read, a write, an unconditional swap or a compare-and-swap. A lock flag turns a read into a load-linked and a write into a store-conditional. Along with the request, the cache presents the line's bytes, its state bits (valid, writable, dirty), an identifier for the line and a miss flag. The unit returns the old bytes at the addressed offset, the updated line image with a write enable, the new dirty bit, hit, fetch and error flags, and the store-conditional outcome.

Requests enter on a valid/ready stream and responses leave on a second valid/ready stream, one response per accepted request, registered one cycle after acceptance. A response is held unchanged while the consumer keeps `rsp_ready` low. While a response is stalled, the unit accepts no new request. The unit keeps one load-linked reservation, tagged with the line identifier. A store-conditional to the same line that hits a writable line consumes it, and a plain write to that line cancels it.

Top module: `line_atomic_unit`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response is on `rsp_valid` from the next edge and stays unchanged until it is taken with `rsp_ready` high. `req_ready` is high exactly when no response is waiting or the waiting one is being taken.
- R2: Size code s (`req_size`) means 2^s bytes. Bytes are little-endian, so line byte `req_off`+j lands in `rsp_rdata` bits 8j+7:8j, and unused upper bytes are zero. A read (`req_op`=0) hits when `line_miss` is 0 and `line_valid` is 1.
- R3: A write (`req_op`=1, lock 0) hits only on a writable valid present line. It replaces the addressed bytes with the low bytes of `req_wdata` and leaves the other bytes unchanged. It raises `rsp_line_we` and sets `rsp_dirty`.
- R4: A swap (`req_op`=2) returns the old bytes and stores the new ones when it hits a writable line.
- R5: A compare-and-swap (`req_op`=3) compares the stored bytes with the low bytes of `req_cmp` and writes only on equality. The old bytes come back either way. A mismatch leaves the line and the dirty bit unchanged.
- R6: A compare-and-swap whose size is not 4 or 8 bytes (size code 0 or 1) raises `rsp_err` and writes nothing.
- R7: When `req_off` plus the byte count exceeds the line size, `rsp_err` is raised. Hit, fetch and write enable stay low, and the reservation is left untouched.
- R8: A permission failure is treated as a miss: the line is absent, or invalid, or read-only for a writing op. The response then has hit 0, fetch 1, write enable 0 and zero read data, and `rsp_dirty` equals `line_dirty`.
- R9: A locked read that hits records a reservation for `req_line_id`. A later locked read that hits moves the reservation.
- R10: A store-conditional writes and returns `rsp_sc_ok`=1 only if it hits a writable line holding the reservation for its `req_line_id`. Otherwise it returns 0 and writes nothing. Every store-conditional that is not an error clears the reservation.
- R11: A store-conditional with `line_miss`=1 fails at once: `rsp_sc_ok`=0 and `rsp_fetch`=0.
- R12: A write, swap or successful compare-and-swap that changes the reserved line clears the reservation. The same ops on another line leave it in place.
- R13: After reset no response is pending, `req_ready` is high and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 read, 1 write, 2 swap, 3 compare-and-swap |
| req_lock | input | 1 | Locked read / conditional write |
| req_off | input | OFF_W | Byte offset in line |
| req_size | input | 2 | Size code, 2^code bytes |
| req_wdata | input | 64 | New value, little-endian |
| req_cmp | input | 64 | Compare operand |
| req_line_id | input | ID_W | Identifier of the line |
| line_miss | input | 1 | Line not present |
| line_valid | input | 1 | Line valid bit |
| line_writable | input | 1 | Line writable bit |
| line_dirty | input | 1 | Line dirty bit |
| line_data | input | LINE_BYTES*8 | Current line bytes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Old bytes at the offset |
| rsp_line_data | output | LINE_BYTES*8 | Updated line image |
| rsp_line_we | output | 1 | Line image must be stored |
| rsp_dirty | output | 1 | New dirty bit |
| rsp_hit | output | 1 | Access satisfied here |
| rsp_fetch | output | 1 | Request must go to the next level |
| rsp_sc_ok | output | 1 | Store-conditional outcome |
| rsp_err | output | 1 | Illegal size or range |

## Verification
The hardest state to reach from the ports is a reservation that has survived traffic. The stimulus has to build it with a locked read, then send requests that should or should not touch it before the store-conditional that reveals it. Those requests are writes to other lines, out-of-range requests and a store-conditional to another line. The bench runs these sequences back to back, and also while the response consumer stalls in a repeating pattern. This proves that reservation updates follow acceptance order and not response order.

// File: rtl/line_atomic_pkg.sv
package line_atomic_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_CSWAP = 2'd3
  } lop_e;

  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned WORD_BITS  = WORD_BYTES * 8;

  function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/line_atomic_extract.sv
module line_atomic_extract
  import line_atomic_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES*8-1:0] line_i,
  input  logic [OFF_W-1:0]        off_i,
  input  logic [3:0]              nbytes_i,
  output logic [WORD_BITS-1:0]    old_o
);
  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
    logic [7:0] pick;
    always_comb begin
      pick = 8'h00;
      for (int k = 0; k < LINE_BYTES; k++) begin
        if ((j < int'(nbytes_i)) && (k == int'(off_i) + j))
          pick = line_i[k*8 +: 8];
      end
    end
    assign old_o[j*8 +: 8] = pick;
  end
endmodule

// File: rtl/line_atomic_merge.sv
module line_atomic_merge
  import line_atomic_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES*8-1:0] line_i,
  input  logic [OFF_W-1:0]        off_i,
  input  logic [3:0]              nbytes_i,
  input  logic [WORD_BITS-1:0]    wdata_i,
  output logic [LINE_BYTES*8-1:0] line_o
);
  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    logic [7:0] nb;
    always_comb begin
      nb = line_i[i*8 +: 8];
      for (int j = 0; j < WORD_BYTES; j++) begin
        if ((j < int'(nbytes_i)) && (i == int'(off_i) + j))
          nb = wdata_i[j*8 +: 8];
      end
    end
    assign line_o[i*8 +: 8] = nb;
  end
endmodule

// File: rtl/line_atomic_resv.sv
module line_atomic_resv #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] id_i,
  output logic            held_o,
  output logic [ID_W-1:0] id_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= 1'b0;
      id_o   <= '0;
    end else if (fire_i) begin
      if (set_i) begin
        held_o <= 1'b1;
        id_o   <= id_i;
      end else if (clr_i) begin
        held_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/line_atomic_decide.sv
module line_atomic_decide
  import line_atomic_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned OFF_W      = $clog2(LINE_BYTES),
  parameter int unsigned ID_W       = 8
) (
  input  lop_e                  op_i,
  input  logic                  lock_i,
  input  logic [OFF_W-1:0]      off_i,
  input  logic [1:0]            size_i,
  input  logic [WORD_BITS-1:0]  cmp_i,
  input  logic [WORD_BITS-1:0]  old_i,
  input  logic [ID_W-1:0]       id_i,
  input  logic                  miss_i,
  input  logic                  valid_i,
  input  logic                  writable_i,
  input  logic                  res_held_i,
  input  logic [ID_W-1:0]       res_id_i,
  output logic [3:0]            nbytes_o,
  output logic                  err_o,
  output logic                  hit_o,
  output logic                  write_o,
  output logic                  fetch_o,
  output logic                  sc_ok_o,
  output logic                  res_set_o,
  output logic                  res_clr_o
);
  localparam int unsigned SPAN_W = OFF_W + 5;

  logic [SPAN_W-1:0] span;
  logic              range_bad, cas_bad;
  logic              writes_line, present, perm;
  logic              is_ll, is_sc, res_match, cas_eq;
  logic [WORD_BYTES-1:0] lane_eq;

  assign nbytes_o  = size_to_bytes(size_i);
  assign span      = SPAN_W'(off_i) + SPAN_W'(nbytes_o);
  assign range_bad = span > SPAN_W'(LINE_BYTES);
  assign cas_bad   = (op_i == OP_CSWAP) && !size_i[1];
  assign err_o     = range_bad || cas_bad;

  assign writes_line = (op_i != OP_READ);
  assign present     = !miss_i && valid_i;
  assign perm        = writes_line ? (present && writable_i) : present;

  assign is_ll     = (op_i == OP_READ) && lock_i;
  assign is_sc     = (op_i == OP_WRITE) && lock_i;
  assign res_match = res_held_i && (res_id_i == id_i);

  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_cmp
    assign lane_eq[j] = (j >= int'(nbytes_o)) || (old_i[j*8 +: 8] == cmp_i[j*8 +: 8]);
  end
  assign cas_eq = &lane_eq;

  assign hit_o = !err_o && perm;

  always_comb begin
    write_o = 1'b0;
    if (hit_o) begin
      unique case (op_i)
        OP_READ:  write_o = 1'b0;
        OP_WRITE: write_o = !is_sc || res_match;
        OP_SWAP:  write_o = 1'b1;
        OP_CSWAP: write_o = cas_eq;
        default:  write_o = 1'b0;
      endcase
    end
  end

  assign sc_ok_o   = is_sc && hit_o && res_match;
  assign fetch_o   = !err_o && !perm && !(is_sc && miss_i);
  assign res_set_o = is_ll && hit_o;
  assign res_clr_o = !err_o && (is_sc || (write_o && (id_i == res_id_i)));
endmodule

// File: rtl/line_atomic_unit.sv
module line_atomic_unit
  import line_atomic_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned ID_W       = 8,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_lock,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       req_cmp,
  input  logic [ID_W-1:0]   req_line_id,
  input  logic              line_miss,
  input  logic              line_valid,
  input  logic              line_writable,
  input  logic              line_dirty,
  input  logic [LINE_W-1:0] line_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic [LINE_W-1:0] rsp_line_data,
  output logic              rsp_line_we,
  output logic              rsp_dirty,
  output logic              rsp_hit,
  output logic              rsp_fetch,
  output logic              rsp_sc_ok,
  output logic              rsp_err
);
  logic              fire;
  logic [3:0]        nbytes;
  logic [63:0]       old_val;
  logic [LINE_W-1:0] merged;
  logic              err, hit, do_write, fetch, sc_ok, res_set, res_clr;
  logic              res_held;
  logic [ID_W-1:0]   res_id;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  line_atomic_extract #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_extract (
    .line_i  (line_data),
    .off_i   (req_off),
    .nbytes_i(nbytes),
    .old_o   (old_val)
  );

  line_atomic_merge #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_merge (
    .line_i  (line_data),
    .off_i   (req_off),
    .nbytes_i(nbytes),
    .wdata_i (req_wdata),
    .line_o  (merged)
  );

  line_atomic_decide #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .ID_W(ID_W)) u_decide (
    .op_i      (lop_e'(req_op)),
    .lock_i    (req_lock),
    .off_i     (req_off),
    .size_i    (req_size),
    .cmp_i     (req_cmp),
    .old_i     (old_val),
    .id_i      (req_line_id),
    .miss_i    (line_miss),
    .valid_i   (line_valid),
    .writable_i(line_writable),
    .res_held_i(res_held),
    .res_id_i  (res_id),
    .nbytes_o  (nbytes),
    .err_o     (err),
    .hit_o     (hit),
    .write_o   (do_write),
    .fetch_o   (fetch),
    .sc_ok_o   (sc_ok),
    .res_set_o (res_set),
    .res_clr_o (res_clr)
  );

  line_atomic_resv #(.ID_W(ID_W)) u_resv (
    .clk   (clk),
    .rst_n (rst_n),
    .fire_i(fire),
    .set_i (res_set),
    .clr_i (res_clr),
    .id_i  (req_line_id),
    .held_o(res_held),
    .id_o  (res_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= fire || (rsp_valid && !rsp_ready);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata     <= '0;
      rsp_line_data <= '0;
      rsp_line_we   <= 1'b0;
      rsp_dirty     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_fetch     <= 1'b0;
      rsp_sc_ok     <= 1'b0;
      rsp_err       <= 1'b0;
    end else if (fire) begin
      rsp_rdata     <= hit ? old_val : 64'd0;
      rsp_line_data <= do_write ? merged : line_data;
      rsp_line_we   <= do_write;
      rsp_dirty     <= line_dirty || do_write;
      rsp_hit       <= hit;
      rsp_fetch     <= fetch;
      rsp_sc_ok     <= sc_ok;
      rsp_err       <= err;
    end
  end
endmodule

// File: rtl/line_atomic_unit_chk.sv
module line_atomic_unit_chk #(
  parameter int unsigned LINE_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [63:0]       rsp_rdata,
  input logic [LINE_W-1:0] rsp_line_data,
  input logic              rsp_line_we,
  input logic              rsp_dirty,
  input logic              rsp_hit,
  input logic              rsp_fetch,
  input logic              rsp_sc_ok,
  input logic              rsp_err
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_rdata, rsp_line_data, rsp_line_we,
      rsp_dirty, rsp_hit, rsp_fetch, rsp_sc_ok, rsp_err})));

  p_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_line_we) |-> rsp_dirty);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!rsp_line_we && !rsp_hit && !rsp_fetch && !rsp_sc_ok));

  p_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fetch) |-> (!rsp_hit && !rsp_line_we && rsp_rdata == 64'd0));

  p_sc_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_sc_ok) |-> (rsp_line_we && rsp_hit));
endmodule

bind line_atomic_unit line_atomic_unit_chk #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .rsp_line_data(rsp_line_data),
  .rsp_line_we  (rsp_line_we),
  .rsp_dirty    (rsp_dirty),
  .rsp_hit      (rsp_hit),
  .rsp_fetch    (rsp_fetch),
  .rsp_sc_ok    (rsp_sc_ok),
  .rsp_err      (rsp_err)
);

// File: tb/line_atomic_unit_bench.sv
`timescale 1ns/1ps
module line_atomic_unit_bench;
  localparam int LB = 16;

  typedef struct packed {
    logic [63:0]     rd;
    logic [LB*8-1:0] ln;
    logic we, dirty, hit, fetch, sc, err;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic req_lock = 1'b0;
  logic [3:0] req_off = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0, req_cmp = '0;
  logic [7:0] req_line_id = '0;
  logic line_miss = 1'b0, line_valid = 1'b0, line_writable = 1'b0, line_dirty = 1'b0;
  logic [LB*8-1:0] line_data = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic [LB*8-1:0] rsp_line_data;
  logic rsp_line_we, rsp_dirty, rsp_hit, rsp_fetch, rsp_sc_ok, rsp_err;

  int checks = 0, fails = 0, cyc = 0;
  bit stall = 1'b0, pend_pop = 1'b0;
  exp_t expq[$];
  string tagq[$];
  bit m_res_v = 1'b0;
  int m_res_id = 0;

  always #2 clk = ~clk;

  line_atomic_unit u_line_atomic_unit (.*);

  function automatic logic [LB*8-1:0] pat(input int base);
    logic [LB*8-1:0] r;
    for (int i = 0; i < LB; i++) r[i*8 +: 8] = 8'(base + i);
    return r;
  endfunction

  function automatic exp_t model(input int op, input bit lk, input int off, input int sz,
      input logic [63:0] wd, input logic [63:0] cmp, input int id,
      input bit miss, input bit v, input bit w, input bit d, input logic [LB*8-1:0] ln);
    exp_t e;
    int nb;
    bit err, perm, sc, match, eq;
    logic [63:0] old;
    nb = 1 << sz;
    err = (off + nb > LB) || (op == 3 && sz < 2);
    old = '0;
    if (!err) for (int j = 0; j < nb; j++) old[j*8 +: 8] = ln[(off + j)*8 +: 8];
    perm = !miss && v && (op == 0 || w);
    sc = (op == 1) && lk;
    match = m_res_v && (m_res_id == id);
    eq = 1'b1;
    for (int j = 0; j < nb && j < 8; j++) if (old[j*8 +: 8] != cmp[j*8 +: 8]) eq = 1'b0;
    e.err = err;
    e.hit = !err && perm;
    e.we = e.hit && ((op == 1 && (!sc || match)) || op == 2 || (op == 3 && eq));
    e.sc = sc && e.hit && match;
    e.fetch = !err && !perm && !(sc && miss);
    e.rd = e.hit ? old : 64'd0;
    e.ln = ln;
    if (e.we) for (int j = 0; j < nb; j++) e.ln[(off + j)*8 +: 8] = wd[j*8 +: 8];
    e.dirty = d || e.we;
    if (!err) begin
      if (op == 0 && lk && e.hit) begin m_res_v = 1'b1; m_res_id = id; end
      else if (sc) m_res_v = 1'b0;
      else if (e.we && id == m_res_id) m_res_v = 1'b0;
    end
    return e;
  endfunction

  task automatic send(input string tag, input int op, input bit lk, input int off, input int sz,
      input logic [63:0] wd, input logic [63:0] cmp, input int id,
      input bit miss, input bit v, input bit w, input bit d, input logic [LB*8-1:0] ln);
    exp_t e;
    @(negedge clk); #1;
    req_op = 2'(op); req_lock = lk; req_off = 4'(off); req_size = 2'(sz);
    req_wdata = wd; req_cmp = cmp; req_line_id = 8'(id);
    line_miss = miss; line_valid = v; line_writable = w; line_dirty = d; line_data = ln;
    req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    e = model(op, lk, off, sz, wd, cmp, id, miss, v, w, d, ln);
    expq.push_back(e);
    tagq.push_back(tag);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pend_pop && expq.size() > 0) begin void'(expq.pop_front()); void'(tagq.pop_front()); end
      if (rsp_valid) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
        end else if ({rsp_rdata, rsp_line_data, rsp_line_we, rsp_dirty, rsp_hit, rsp_fetch,
                      rsp_sc_ok, rsp_err} !== expq[0]) begin
          fails++;
          $display("FAIL %s actual rd=%h ln=%h we%b d%b h%b f%b sc%b e%b expected rd=%h ln=%h we%b d%b h%b f%b sc%b e%b",
            tagq[0], rsp_rdata, rsp_line_data, rsp_line_we, rsp_dirty, rsp_hit, rsp_fetch,
            rsp_sc_ok, rsp_err, expq[0].rd, expq[0].ln, expq[0].we, expq[0].dirty,
            expq[0].hit, expq[0].fetch, expq[0].sc, expq[0].err);
        end
      end else if (expq.size() > 0) begin
        checks++; fails++;
        $display("FAIL R1 missing response: actual valid=0 expected valid=1 (%s)", tagq[0]);
      end
      rsp_ready = stall ? (cyc % 3 == 0) : 1'b1;
      pend_pop = rsp_valid && rsp_ready;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [LB*8-1:0] L;
    L = pat(8'hA0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R13 reset: actual valid=%b ready=%b expected valid=0 ready=1", rsp_valid, req_ready);
    end
    send("R13 no reservation after reset", 1, 1, 0, 2, 64'h11, 0, 0, 0, 1, 1, 0, L);
    // reads of every size
    send("R2 read 1B", 0, 0, 3, 0, 0, 0, 1, 0, 1, 0, 0, L);
    send("R2 read 2B", 0, 0, 5, 1, 0, 0, 1, 0, 1, 0, 1, L);
    send("R2 read 4B", 0, 0, 4, 2, 0, 0, 1, 0, 1, 0, 0, L);
    send("R2 read 8B at end", 0, 0, 8, 3, 0, 0, 1, 0, 1, 1, 0, L);
    send("R8 read miss", 0, 0, 0, 2, 0, 0, 1, 1, 1, 1, 0, L);
    send("R8 read invalid", 0, 0, 0, 2, 0, 0, 1, 0, 0, 0, 1, L);
    send("R3 write 4B", 1, 0, 6, 2, 64'hDEADBEEF, 0, 2, 0, 1, 1, 0, L);
    send("R3 write 1B", 1, 0, 15, 0, 64'h5A, 0, 2, 0, 1, 1, 1, L);
    send("R8 write readonly", 1, 0, 0, 2, 64'h1, 0, 2, 0, 1, 0, 0, L);
    send("R4 swap 8B", 2, 0, 0, 3, 64'h0102030405060708, 0, 3, 0, 1, 1, 0, L);
    send("R4 swap 2B", 2, 0, 9, 1, 64'hCAFE, 0, 3, 0, 1, 1, 0, L);
    send("R5 cas 4B match", 3, 0, 4, 2, 64'h12345678, 64'hA7A6A5A4, 3, 0, 1, 1, 0, L);
    send("R5 cas 8B match", 3, 0, 8, 3, 64'h1122334455667788, 64'hAFAEADACABAAA9A8, 3, 0, 1, 1, 0, L);
    send("R5 cas mismatch", 3, 0, 4, 2, 64'h12345678, 64'hA7A6A5A5, 3, 0, 1, 1, 0, L);
    send("R6 cas 2B error", 3, 0, 4, 1, 64'h1234, 64'hA5A4, 3, 0, 1, 1, 0, L);
    send("R6 cas 1B error", 3, 0, 4, 0, 64'h12, 64'hA4, 3, 0, 1, 1, 0, L);
    send("R7 range 8B at 12", 0, 0, 12, 3, 0, 0, 3, 0, 1, 1, 0, L);
    send("R7 range 2B at 15", 1, 0, 15, 1, 64'h1, 0, 3, 0, 1, 1, 0, L);
    // reservation scenarios
    send("R9 LL line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R10 SC line5 ok", 1, 1, 0, 2, 64'h77, 0, 5, 0, 1, 1, 0, L);
    send("R10 SC line5 again fails", 1, 1, 0, 2, 64'h77, 0, 5, 0, 1, 1, 0, L);
    send("R9 LL line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R10 SC line6 fails", 1, 1, 0, 2, 64'h77, 0, 6, 0, 1, 1, 0, L);
    send("R10 SC line5 after clear fails", 1, 1, 0, 2, 64'h77, 0, 5, 0, 1, 1, 0, L);
    send("R9 LL line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R11 SC miss", 1, 1, 0, 2, 64'h77, 0, 5, 1, 0, 0, 0, L);
    send("R9 LL line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R12 write other line", 1, 0, 0, 2, 64'h9, 0, 7, 0, 1, 1, 0, L);
    send("R12 reservation kept", 1, 1, 0, 2, 64'h88, 0, 5, 0, 1, 1, 0, L);
    send("R9 LL line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R12 swap same line", 2, 0, 4, 2, 64'h9, 0, 5, 0, 1, 1, 0, L);
    send("R12 reservation lost", 1, 1, 0, 2, 64'h88, 0, 5, 0, 1, 1, 0, L);
    send("R9 LL line4", 0, 1, 0, 2, 0, 0, 4, 0, 1, 1, 0, L);
    send("R9 LL moves to line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R9 SC line4 fails", 1, 1, 0, 2, 64'h1, 0, 4, 0, 1, 1, 0, L);
    send("R9 LL line5", 0, 1, 0, 2, 0, 0, 5, 0, 1, 1, 0, L);
    send("R7 SC out of range", 1, 1, 14, 3, 64'h1, 0, 5, 0, 1, 1, 0, L);
    send("R7 reservation untouched", 1, 1, 0, 2, 64'h3, 0, 5, 0, 1, 1, 0, L);
    // back-pressure
    stall = 1'b1;
    for (int k = 0; k < 24; k++)
      send("R1 stalled stream", k % 4, (k % 5) == 0, k % 9, k % 4, 64'(k * 64'h0101010101),
           64'hA7A6A5A4, k % 3, (k % 7) == 6, 1, (k % 2) == 0, 0, pat(k * 16));
    stall = 1'b0;
    while (expq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule